// File: doc/BRIEF.md
# Column Broadcast Turn Sequencer

This block models one column of processing nodes that share a single broadcast path. After a start pulse, each node sends a vector of 32-bit words in turn. Its words climb toward the head node (row 0), which turns them onto a separate downward channel. Every node then receives them, and every node except the bottom one passes them further south. The sender itself also receives its own vector.

Turns are handed over in-band. When a node has sent its last word, it appends a control token, marked by a sideband flag bit. Each node keeps its own turn position and advances it whenever a token passes its downward stage. A node begins sending when its position equals its own row number. The token never appears on any node's receive output.

Each hop holds one register per direction. The column moves only when every node can accept. When the token from the last row reaches the bottom node, the block raises done for one cycle and goes idle until the next start.

Top module: `col_bcast_seq`

## Requirements
- R1: Word w of node n's vector is taken from `send_vec[(n*VEC_LEN+w)*32 +: 32]` and is delivered unchanged as one 32-bit `rx_data` word.
- R2: After an accepted start, every node, including the sender, receives NODES*VEC_LEN words. Row 0's vector comes first, then row 1 and so on, each vector in word-index order.
- R3: At most one node injects words at any time, and a node never injects while a word from further south is passing through its upward stage. As a result, vectors never interleave.
- R4: The control token that ends each turn is never presented on `rx_valid`, so each node's word count is exact.
- R5: The column advances only on cycles where every `rx_ready` bit is 1, and a word counts as delivered only on such a cycle. On any other cycle, `rx_valid` and `rx_data` hold their values.
- R6: `done` is 1 for exactly one cycle per run, after the last data word has been delivered to every node.
- R7: A start pulse arriving while a sequence is running is ignored, and that run still produces exactly one done pulse and correct streams.
- R8: Once `done` has been raised, `rx_valid` stays 0 on all nodes until the next start.
- R9: After reset, `rx_valid` is all zeros and `done` is 0.
- R10: A later start, with new vector contents, runs the whole sequence again and delivers the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a sequence when the block is idle |
| send_vec | input | NODES*VEC_LEN*32 | Local send buffers for all nodes, node-major |
| rx_ready | input | NODES | Per-node ability to take a received word |
| rx_valid | output | NODES | Per-node received word present |
| rx_data | output | NODES*32 | Per-node received word, node n at bits n*32 |
| done | output | 1 | One-cycle pulse when every turn has completed |

## Verification
A turn position that advances wrongly in one node shows up at the ports as a wrong order or a missing vector in that node's stream. When this happens, the node injects early, which garbles the column within a few cycles. When the node never reaches its turn, no done pulse arrives. A stage that fails to hold under a stall shows up as duplicated or lost words, and the exact word count of each node reveals it at the end of the run. Leftover tokens, or flits that outlive the sequence, appear as `rx_valid` activity in the idle window after `done`.

// File: rtl/col_bcast_pkg.sv
package col_bcast_pkg;

   localparam int WORD_W = 32;

   // One flit on a column channel: valid, token flag, payload.
   typedef struct packed {
      logic              vld;
      logic              tok;
      logic [WORD_W-1:0] dat;
   } flit_t;

   localparam flit_t FLIT_IDLE = '0;

endpackage

// File: rtl/col_bcast_src.sv
// Per-node turn tracker and word sequencer.
module col_bcast_src
   import col_bcast_pkg::*;
#(
   parameter int NODES   = 4,
   parameter int VEC_LEN = 4,
   parameter int ROW     = 0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      run_start,
   input  logic                      busy,
   input  logic                      adv,
   input  logic [VEC_LEN*WORD_W-1:0] vec,
   input  flit_t                     dn_seen,
   output flit_t                     src_flit,
   output logic                      src_on,
   output logic                      turns_full
);

   localparam int POS_W = $clog2(NODES + 1);
   localparam int IDX_W = $clog2(VEC_LEN + 1);

   logic [POS_W-1:0]  pos_q;
   logic [IDX_W-1:0]  idx_q;
   logic              sent_q;
   logic              at_tok;
   logic [WORD_W-1:0] word;

   assign at_tok     = (idx_q == IDX_W'(VEC_LEN));
   assign src_on     = busy && !sent_q && (pos_q == POS_W'(ROW));
   assign turns_full = (pos_q == POS_W'(NODES));

   always_comb begin
      word = '0;
      for (int w = 0; w < VEC_LEN; w++) begin
         if (idx_q == IDX_W'(w)) word = vec[w*WORD_W +: WORD_W];
      end
   end

   always_comb begin
      src_flit.vld = src_on;
      src_flit.tok = at_tok;
      src_flit.dat = at_tok ? '0 : word;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q  <= '0;
         idx_q  <= '0;
         sent_q <= 1'b0;
      end else if (run_start) begin
         pos_q  <= '0;
         idx_q  <= '0;
         sent_q <= 1'b0;
      end else if (adv && busy) begin
         if (dn_seen.vld && dn_seen.tok && (pos_q < POS_W'(NODES)))
            pos_q <= pos_q + 1'b1;
         if (src_on) begin
            if (at_tok) begin
               sent_q <= 1'b1;
               idx_q  <= '0;
            end else begin
               idx_q  <= idx_q + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/col_bcast_hop.sv
// One node's upward and downward channel registers.
module col_bcast_hop
   import col_bcast_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic              src_on,
   input  flit_t             src_flit,
   input  flit_t             up_in,
   input  flit_t             dn_in,
   output flit_t             up_q,
   output flit_t             dn_q,
   output logic              rx_vld,
   output logic [WORD_W-1:0] rx_dat
);

   flit_t up_d;

   assign up_d   = src_on ? src_flit : up_in;
   assign rx_vld = dn_q.vld && !dn_q.tok;
   assign rx_dat = dn_q.dat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         up_q <= FLIT_IDLE;
         dn_q <= FLIT_IDLE;
      end else if (adv) begin
         up_q <= up_d;
         dn_q <= dn_in;
      end
   end

endmodule

// File: rtl/col_bcast_seq.sv
module col_bcast_seq
   import col_bcast_pkg::*;
#(
   parameter int NODES   = 4,
   parameter int VEC_LEN = 4
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            start,
   input  logic [NODES*VEC_LEN*WORD_W-1:0] send_vec,
   input  logic [NODES-1:0]                rx_ready,
   output logic [NODES-1:0]                rx_valid,
   output logic [NODES*WORD_W-1:0]         rx_data,
   output logic                            done
);

   localparam int VEC_W = VEC_LEN * WORD_W;

   if (NODES < 2) begin : g_bad_nodes
      $error("col_bcast_seq: NODES must be at least 2");
   end
   if (VEC_LEN < 1) begin : g_bad_len
      $error("col_bcast_seq: VEC_LEN must be at least 1");
   end

   logic             busy;
   logic             adv;
   logic             run_start;
   logic [NODES-1:0] full_v;
   logic [NODES-1:0] src_on_v;
   logic [NODES-1:0] up_south_vld;

   flit_t up_q     [NODES-1:0];
   flit_t dn_q     [NODES-1:0];
   flit_t up_south [NODES-1:0];
   flit_t dn_north [NODES-1:0];
   flit_t src_f    [NODES-1:0];

   assign adv       = &rx_ready;
   assign run_start = start && !busy;
   // The bottom node is the last to see the final token.
   assign done      = busy && (&full_v);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         busy <= 1'b0;
      else if (run_start) busy <= 1'b1;
      else if (done)      busy <= 1'b0;
   end

   for (genvar i = 0; i < NODES; i++) begin : g_node
      if (i == NODES - 1) begin : g_bottom
         assign up_south[i] = FLIT_IDLE;
      end else begin : g_mid
         assign up_south[i] = up_q[i+1];
      end

      if (i == 0) begin : g_head
         // Turnaround: the upward channel re-enters as the downward channel.
         assign dn_north[i] = up_q[0];
      end else begin : g_below
         assign dn_north[i] = dn_q[i-1];
      end

      assign up_south_vld[i] = up_south[i].vld;

      col_bcast_src #(
         .NODES   (NODES),
         .VEC_LEN (VEC_LEN),
         .ROW     (i)
      ) u_src (
         .clk        (clk),
         .rst_n      (rst_n),
         .run_start  (run_start),
         .busy       (busy),
         .adv        (adv),
         .vec        (send_vec[i*VEC_W +: VEC_W]),
         .dn_seen    (dn_q[i]),
         .src_flit   (src_f[i]),
         .src_on     (src_on_v[i]),
         .turns_full (full_v[i])
      );

      col_bcast_hop u_hop (
         .clk      (clk),
         .rst_n    (rst_n),
         .adv      (adv),
         .src_on   (src_on_v[i]),
         .src_flit (src_f[i]),
         .up_in    (up_south[i]),
         .dn_in    (dn_north[i]),
         .up_q     (up_q[i]),
         .dn_q     (dn_q[i]),
         .rx_vld   (rx_valid[i]),
         .rx_dat   (rx_data[i*WORD_W +: WORD_W])
      );
   end

endmodule

// File: rtl/col_bcast_chk.sv
module col_bcast_chk #(
   parameter int NODES = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [NODES-1:0]       rx_ready,
   input logic [NODES-1:0]       rx_valid,
   input logic [NODES*32-1:0]    rx_data,
   input logic                   done,
   input logic                   busy,
   input logic [NODES-1:0]       src_on_v,
   input logic [NODES-1:0]       up_south_vld
);

   // R3: a single injecting node at a time
   a_r3_one_source: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(src_on_v));

   // R3: local injection never overwrites a word climbing from the south
   a_r3_no_collision: assert property (@(posedge clk) disable iff (!rst_n)
      (src_on_v & up_south_vld) == '0);

   // R5: outputs hold while any node withholds ready
   a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(&rx_ready) |=> ($stable(rx_valid) && $stable(rx_data)));

   // R6: done lasts one cycle
   a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8: nothing is delivered while idle
   a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (rx_valid == '0));

endmodule

bind col_bcast_seq col_bcast_chk #(.NODES(NODES)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .rx_ready     (rx_ready),
   .rx_valid     (rx_valid),
   .rx_data      (rx_data),
   .done         (done),
   .busy         (busy),
   .src_on_v     (src_on_v),
   .up_south_vld (up_south_vld)
);

// File: tb/col_bcast_seq_tb.sv
module col_bcast_seq_tb;

   localparam int N   = 4;
   localparam int L   = 4;
   localparam int TOT = N * L;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [TOT*32-1:0] send_vec = '0;
   logic [N-1:0]      rx_ready = '1;
   logic [N-1:0]      rx_valid;
   logic [N*32-1:0]   rx_data;
   logic              done;

   int tests = 0;
   int fails = 0;
   logic [15:0] lfsr = 16'hACE1;
   logic [31:0] sbuf [N][L];
   logic [31:0] got  [N][TOT];
   int          gcnt [N];

   always #4 clk = ~clk;

   col_bcast_seq #(.NODES(N), .VEC_LEN(L)) u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .send_vec (send_vec),
      .rx_ready (rx_ready),
      .rx_valid (rx_valid),
      .rx_data  (rx_data),
      .done     (done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(rx_valid == '0, "R9", "rx_valid after reset", 32'(rx_valid), 0);
      chk(done == 1'b0, "R9", "done after reset", 32'(done), 0);
   endtask

   // One whole sequence; stall randomises ready, poke fires start mid-run.
   task automatic run_case(input int seed, input bit stall, input bit poke,
                           input string tag);
      int   dcnt = 0;
      int   last_del = -1;
      int   done_cyc = -1;
      int   wide = 0;
      int   idle_bad = 0;
      bit   prev_done = 1'b0;
      int   k = 0;
      for (int n = 0; n < N; n++) begin
         gcnt[n] = 0;
         for (int w = 0; w < L; w++) begin
            sbuf[n][w] = {8'(seed), 8'(n), 16'(w * 37 + 5)} ^ 32'h3F80_0000;
            send_vec[(n*L + w)*32 +: 32] = sbuf[n][w];
         end
      end
      for (k = 0; k < 5000; k++) begin
         @(posedge clk);
         #1;
         start = (k == 0) || (poke && (k % 7 == 3));
         if (stall) begin
            for (int i = 0; i < N; i++) rx_ready[i] = |lfsr[2*i +: 2];
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         end else begin
            rx_ready = '1;
         end
         @(negedge clk);
         for (int i = 0; i < N; i++) begin
            if (rx_valid[i] && (&rx_ready)) begin
               if (gcnt[i] < TOT) got[i][gcnt[i]] = rx_data[i*32 +: 32];
               gcnt[i]++;
               last_del = k;
            end
         end
         if (done) begin
            dcnt++;
            done_cyc = k;
            if (prev_done) wide++;
         end
         prev_done = done;
         if (dcnt != 0) break;
      end
      // Idle window after done: no start, all ready.
      for (int t = 0; t < 40; t++) begin
         @(posedge clk);
         #1;
         start = 1'b0;
         rx_ready = '1;
         @(negedge clk);
         if (rx_valid != '0) idle_bad++;
         if (done) begin
            dcnt++;
            if (prev_done) wide++;
         end
         prev_done = done;
      end
      chk(dcnt == 1, "R6 R7", {tag, " done pulse count"}, 32'(dcnt), 1);
      chk(wide == 0, "R6", {tag, " done width"}, 32'(wide), 0);
      chk(done_cyc > last_del, "R6", {tag, " done after last word"},
          32'(done_cyc), 32'(last_del + 1));
      chk(idle_bad == 0, "R8", {tag, " rx_valid after done"}, 32'(idle_bad), 0);
      for (int i = 0; i < N; i++) begin
         int          bad = 0;
         logic [31:0] a = '0;
         logic [31:0] e = '0;
         chk(gcnt[i] == TOT, "R2 R4 R5", {tag, $sformatf(" word count node %0d", i)},
             32'(gcnt[i]), 32'(TOT));
         for (int j = 0; j < TOT && j < gcnt[i]; j++) begin
            if (got[i][j] !== sbuf[j / L][j % L]) begin
               if (bad == 0) begin
                  a = got[i][j];
                  e = sbuf[j / L][j % L];
               end
               bad++;
            end
         end
         chk(bad == 0, "R1 R2 R3 R10", {tag, $sformatf(" stream node %0d", i)}, a, e);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
   end

   initial begin
      t_reset();
      run_case(1, 1'b0, 1'b0, "basic");
      run_case(2, 1'b1, 1'b0, "stall");
      run_case(3, 1'b0, 1'b1, "start_busy");
      run_case(4, 1'b1, 1'b1, "rerun");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule